// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel. A 32-bit timing word, held in the block, sets three phases for every bus cycle: a setup interval before the strobe, an active phase with the strobe driven low, and a recovery phase with the strobe back high. Each phase lasts its stored count plus one ATA clock cycle. The word holds one set of counts for data transfers (PIO and multiword DMA) and a second set for task-file register accesses. The `taskfile_i` select, sampled with the start request, chooses between the two sets.

The timing word is written one mode at a time. A PIO, multiword DMA or Ultra DMA write changes only the bit fields that belong to that mode and leaves all other bits as they were. The Ultra DMA fields and the enable bits are not used for strobe timing. They are only stored and brought out as decoded outputs.

A transfer begins when `start_i` is seen while the block is idle. At that edge the block captures the direction and the selected counts, so a later change to the timing word does not affect the cycle in progress. `done_o` pulses for one cycle after recovery ends. A new start is accepted in that same cycle.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is asserted and just after it is released, both strobes are high, `busy_o` and `done_o` are 0, and `timing_o` equals the reset word (default 0).
- R2: For a data cycle (`taskfile_i`=0) the phase lengths come from the timing word. Setup lasts bits [24:22]+1 cycles, the strobe is low for bits [8:4]+1 cycles, and recovery lasts bits [3:0]+1 cycles.
- R3: For a task-file cycle (`taskfile_i`=1) the phase lengths come from other fields. Setup lasts bits [27:25]+1 cycles, the strobe is low for bits [17:13]+1 cycles, and recovery lasts bits [12:9]+1 cycles.
- R4: Only the strobe chosen by `write_i` goes low: `diow_n_o` when `write_i`=1, `dior_n_o` when `write_i`=0. The two strobes are never low together.
- R5: Number the cycles after the accepting edge from 0, with S, A and R the phase lengths. The strobe is first low in cycle S. `busy_o` is high in cycles 0 through S+A+R-1. `done_o` is high only in cycle S+A+R, while `busy_o` is 0, and for that one cycle only.
- R6: A start is accepted in the cycle where `done_o` is high, so a new setup phase begins in the next cycle. A start raised while `busy_o` is high is ignored.
- R7: The counts and direction are captured at the accepting edge. A timing-word write during a transfer does not change that transfer. A write in the same cycle as the start takes effect only for later transfers.
- R8: A write with `cfg_we_i`=1 merges `cfg_word_i` into the timing word under a mask chosen by `cfg_mode_i`: 0 (PIO) uses mask 0xCFC3FFFF, 1 (multiword DMA) uses 0x31C001FF, 2 (Ultra DMA) uses 0x303C0000, and 3 changes nothing. The new word is visible on `timing_o` after the write edge.
- R9: The decoded outputs follow the stored word: `udma_en_o`=bit 28, `dma_en_o`=bit 29, `bm_pio_o`=bit 30, `fifo_en_o`=bit 31, `udma_cycles_o`=bits [20:18], `udma_clk2x_o`=bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ATA clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing-word write enable |
| cfg_mode_i | input | 2 | Mode of the write: 0 PIO, 1 multiword DMA, 2 Ultra DMA, 3 none |
| cfg_word_i | input | 32 | Timing word to merge |
| start_i | input | 1 | Start request, accepted while idle |
| write_i | input | 1 | 1 for a write cycle (write strobe), 0 for a read cycle |
| taskfile_i | input | 1 | 1 for task-file counts, 0 for data counts |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-cycle pulse after recovery ends |
| timing_o | output | 32 | Stored timing word |
| udma_en_o | output | 1 | Ultra DMA enable bit |
| dma_en_o | output | 1 | DMA enable bit |
| bm_pio_o | output | 1 | Bus-master-during-PIO bit |
| fifo_en_o | output | 1 | PIO FIFO enable bit |
| udma_cycles_o | output | 3 | Ultra DMA cycle count field |
| udma_clk2x_o | output | 1 | Ultra DMA doubled-clock select |

## Verification
The bench drives inputs on falling edges and samples outputs on falling edges. It counts cycles from 0 after the accepting edge. The strobe should first be low at index S, stay low for A samples, and `done_o` should appear at index S+A+R. The bench computes S, A and R from the field values it wrote, plus one each. A timing-word write shows on `timing_o` at the first falling edge after its write edge, and the bench compares it with a merge it computes from the masks. In back-to-back and mid-transfer tests, the bench raises the start or the write exactly at a known index. It then checks that the next setup begins at index 0, or that the stretch in progress keeps the counts captured at the accepting edge.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 5;

  localparam logic [WORD_W-1:0] MASK_PIO   = 32'hCFC3_FFFF;
  localparam logic [WORD_W-1:0] MASK_MWDMA = 32'h31C0_01FF;
  localparam logic [WORD_W-1:0] MASK_UDMA  = 32'h303C_0000;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    MODE_PIO   = 2'd0,
    MODE_MWDMA = 2'd1,
    MODE_UDMA  = 2'd2,
    MODE_NONE  = 2'd3
  } mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } phase_cnt_t;

  function automatic phase_cnt_t pick_counts(input logic [WORD_W-1:0] w, input logic tf);
    phase_cnt_t c;
    if (tf) begin
      c.setup  = {2'b00, w[27:25]};
      c.active = w[17:13];
      c.recov  = {1'b0, w[12:9]};
    end else begin
      c.setup  = {2'b00, w[24:22]};
      c.active = w[8:4];
      c.recov  = {1'b0, w[3:0]};
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] mode_mask(input mode_e m);
    case (m)
      MODE_PIO:   return MASK_PIO;
      MODE_MWDMA: return MASK_MWDMA;
      MODE_UDMA:  return MASK_UDMA;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/ata_strobe_cfg.sv
module ata_strobe_cfg
  import ata_strobe_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              udma_en_o,
  output logic              dma_en_o,
  output logic              bm_pio_o,
  output logic              fifo_en_o,
  output logic [2:0]        udma_cycles_o,
  output logic              udma_clk2x_o
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] mask;

  assign mask = mode_mask(mode_e'(mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= RESET_WORD;
    else if (we_i) word_q <= (word_q & ~mask) | (data_i & mask);
  end

  assign word_o        = word_q;
  assign udma_en_o     = word_q[28];
  assign dma_en_o      = word_q[29];
  assign bm_pio_o      = word_q[30];
  assign fifo_en_o     = word_q[31];
  assign udma_cycles_o = word_q[20:18];
  assign udma_clk2x_o  = word_q[21];

endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_strobe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              taskfile_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              dior_n_o,
  output logic              diow_n_o,
  output logic              busy_o,
  output logic              done_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] active_q;
  logic [CNT_W-1:0] recov_q;
  logic             wr_q;
  logic             done_q;
  phase_cnt_t       pick;

  // counts chosen from the word as it stands at the accepting edge
  assign pick = pick_counts(word_i, taskfile_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      active_q <= '0;
      recov_q  <= '0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q  <= PH_SETUP;
            cnt_q    <= pick.setup;
            active_q <= pick.active;
            recov_q  <= pick.recov;
            wr_q     <= write_i;
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_ACTIVE;
            cnt_q   <= active_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_RECOV;
            cnt_q   <= recov_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RECOV: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign dior_n_o = !((phase_q == PH_ACTIVE) && !wr_q);
  assign diow_n_o = !((phase_q == PH_ACTIVE) &&  wr_q);
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter logic [31:0] RESET_WORD = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_mode_i,
  input  logic [31:0] cfg_word_i,
  input  logic        start_i,
  input  logic        write_i,
  input  logic        taskfile_i,
  output logic        dior_n_o,
  output logic        diow_n_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] timing_o,
  output logic        udma_en_o,
  output logic        dma_en_o,
  output logic        bm_pio_o,
  output logic        fifo_en_o,
  output logic [2:0]  udma_cycles_o,
  output logic        udma_clk2x_o
);

  logic [WORD_W-1:0] word;

  ata_strobe_cfg #(.RESET_WORD(RESET_WORD)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (cfg_we_i),
    .mode_i        (cfg_mode_i),
    .data_i        (cfg_word_i),
    .word_o        (word),
    .udma_en_o     (udma_en_o),
    .dma_en_o      (dma_en_o),
    .bm_pio_o      (bm_pio_o),
    .fifo_en_o     (fifo_en_o),
    .udma_cycles_o (udma_cycles_o),
    .udma_clk2x_o  (udma_clk2x_o)
  );

  ata_strobe_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .write_i    (write_i),
    .taskfile_i (taskfile_i),
    .word_i     (word),
    .dior_n_o   (dior_n_o),
    .diow_n_o   (diow_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign timing_o = word;

endmodule

// File: rtl/ata_strobe_gen_chk.sv
module ata_strobe_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [1:0]  cfg_mode_i,
  input logic        start_i,
  input logic        dior_n_o,
  input logic        diow_n_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] timing_o
);

  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dior_n_o || diow_n_o));

  a_r4_strobe_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_n_o || !diow_n_o) |-> busy_o);

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r8_udma_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'd2) |=>
      (((timing_o ^ $past(timing_o)) & ~32'h303C_0000) == 32'h0));

  a_r8_mwdma_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'd1) |=>
      (((timing_o ^ $past(timing_o)) & ~32'h31C0_01FF) == 32'h0));

  a_r8_none_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'd3) |=> $stable(timing_o));

endmodule

bind ata_strobe_gen ata_strobe_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_mode_i (cfg_mode_i),
  .start_i    (start_i),
  .dior_n_o   (dior_n_o),
  .diow_n_o   (diow_n_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timing_o   (timing_o)
);

// File: tb/ata_strobe_gen_tb.sv
module ata_strobe_gen_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_mode_i = 2'd0;
  logic [31:0] cfg_word_i = 32'h0;
  logic        start_i = 1'b0;
  logic        write_i = 1'b0;
  logic        taskfile_i = 1'b0;
  logic        dior_n_o, diow_n_o, busy_o, done_o;
  logic [31:0] timing_o;
  logic        udma_en_o, dma_en_o, bm_pio_o, fifo_en_o, udma_clk2x_o;
  logic [2:0]  udma_cycles_o;

  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  logic [31:0] model = 32'h0;

  always #2 clk_i = ~clk_i;

  ata_strobe_gen u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [1:0] mode);
    logic [31:0] m;
    case (mode)
      2'd0:    m = 32'hCFC3_FFFF;
      2'd1:    m = 32'h31C0_01FF;
      2'd2:    m = 32'h303C_0000;
      default: m = 32'h0;
    endcase
    return (old & ~m) | (d & m);
  endfunction

  task automatic check_decode();
    chk(udma_en_o == model[28], "R9", "udma_en", udma_en_o, model[28]);
    chk(dma_en_o == model[29], "R9", "dma_en", dma_en_o, model[29]);
    chk(bm_pio_o == model[30], "R9", "bm_pio", bm_pio_o, model[30]);
    chk(fifo_en_o == model[31], "R9", "fifo_en", fifo_en_o, model[31]);
    chk(udma_cycles_o == model[20:18], "R9", "udma_cycles", udma_cycles_o, model[20:18]);
    chk(udma_clk2x_o == model[21], "R9", "udma_clk2x", udma_clk2x_o, model[21]);
  endtask

  task automatic cfg_write(input logic [1:0] mode, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_mode_i = mode; cfg_word_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model = merge(model, d, mode);
    chk(timing_o == model, "R8", "timing word", timing_o, model);
  endtask

  // call at a falling edge; poke_k raises start mid-transfer, cfg_k writes a new word
  task automatic transfer(input bit wr, input bit tf, input int poke_k, input int cfg_k,
                          input logic [31:0] cfg_val, input bit chain, input string tag);
    int s, a, r, first_low, low_cnt, other_low, done_k, busy_bad;
    bit stb, oth;
    s = (tf ? int'(model[27:25]) : int'(model[24:22])) + 1;
    a = (tf ? int'(model[17:13]) : int'(model[8:4])) + 1;
    r = (tf ? int'(model[12:9])  : int'(model[3:0])) + 1;
    first_low = -1; low_cnt = 0; other_low = 0; done_k = -1; busy_bad = 0;
    start_i = 1'b1; write_i = wr; taskfile_i = tf;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      cfg_we_i = 1'b0;
      if (k == poke_k) start_i = 1'b1;
      if (k == cfg_k) begin
        cfg_we_i = 1'b1; cfg_mode_i = 2'd0; cfg_word_i = cfg_val;
        model = merge(model, cfg_val, 2'd0);
      end
      stb = wr ? diow_n_o : dior_n_o;
      oth = wr ? dior_n_o : diow_n_o;
      if (!stb) begin
        if (first_low < 0) first_low = k;
        low_cnt++;
      end
      if (!oth) other_low++;
      if (done_o) begin
        done_k = k;
        chk(!busy_o, "R5", "busy at done", busy_o, 0);
        if (chain) start_i = 1'b1;
        break;
      end
      if (!busy_o) busy_bad++;
    end
    chk(first_low == s, tag, "setup length", first_low, s);
    chk(low_cnt == a, tag, "active length", low_cnt, a);
    chk(done_k == s + a + r, "R5", "done index", done_k, s + a + r);
    chk(other_low == 0, "R4", "wrong strobe low cycles", other_low, 0);
    chk(busy_bad == 0, "R5", "busy gaps", busy_bad, 0);
    if (!chain) begin
      cfg_we_i = 1'b0;
      @(negedge clk_i);
      chk(!done_o, "R5", "done pulse width", done_o, 0);
      chk(!busy_o, "R6", "idle after done", busy_o, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sv[3] = '{0, 3, 7};
    int av[3] = '{0, 5, 31};
    int rv[2] = '{0, 15};
    logic [31:0] w;

    @(negedge clk_i);
    // R1 reset state
    chk(dior_n_o && diow_n_o, "R1", "strobes high in reset", {dior_n_o, diow_n_o}, 3);
    chk(!busy_o && !done_o, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    chk(timing_o == 32'h0, "R1", "reset word", timing_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dior_n_o && diow_n_o && !busy_o && !done_o, "R1", "idle after reset",
        {dior_n_o, diow_n_o, busy_o, done_o}, 12);
    check_decode();

    // R8 / R9 mode merges
    cfg_write(2'd0, 32'hFFFF_FFFF); check_decode();
    cfg_write(2'd1, 32'h0000_0000); check_decode();
    cfg_write(2'd2, 32'hFFFF_FFFF); check_decode();
    cfg_write(2'd3, 32'h0000_0000); check_decode();
    cfg_write(2'd1, 32'hA5A5_5A5A); check_decode();
    cfg_write(2'd2, 32'h0000_0000); check_decode();
    cfg_write(2'd0, 32'h1234_5678); check_decode();

    // R2 / R3 / R4 / R5 sweep
    foreach (sv[i]) foreach (av[j]) foreach (rv[m]) begin
      w = (32'((sv[i] + 5) % 8) << 25) | (32'(sv[i]) << 22)
        | (32'((av[j] + 7) % 32) << 13) | (32'((rv[m] + 9) % 16) << 9)
        | (32'(av[j]) << 4) | 32'(rv[m]);
      cfg_write(2'd0, w);
      for (int wr = 0; wr < 2; wr++) begin
        for (int tf = 0; tf < 2; tf++) begin
          transfer(wr[0], tf[0], -1, -1, 32'h0, 1'b0, tf ? "R3" : "R2");
        end
      end
    end

    // R6 back-to-back: second start raised in the done cycle
    cfg_write(2'd0, (32'd2 << 22) | (32'd3 << 4) | 32'd1);
    transfer(1'b0, 1'b0, -1, -1, 32'h0, 1'b1, "R6");
    transfer(1'b1, 1'b0, -1, -1, 32'h0, 1'b0, "R6");

    // R6 start while busy is ignored
    transfer(1'b0, 1'b0, 1, -1, 32'h0, 1'b0, "R6");

    // R7 word change during a transfer keeps captured counts
    cfg_write(2'd0, (32'd4 << 22) | (32'd6 << 4) | 32'd5);
    transfer(1'b1, 1'b0, -1, 1, (32'd1 << 22) | (32'd20 << 4) | 32'd2, 1'b0, "R7");
    transfer(1'b1, 1'b0, -1, -1, 32'h0, 1'b0, "R7");

    // R7 write in the same cycle as start: start uses old word
    cfg_we_i = 1'b1; cfg_mode_i = 2'd0; cfg_word_i = (32'd7 << 22) | (32'd9 << 4) | 32'd3;
    transfer(1'b0, 1'b0, -1, -1, 32'h0, 1'b0, "R7");
    model = merge(model, (32'd7 << 22) | (32'd9 << 4) | 32'd3, 2'd0);
    chk(timing_o == model, "R7", "same-cycle write landed", timing_o, model);
    transfer(1'b0, 1'b0, -1, -1, 32'h0, 1'b0, "R7");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule